// File: doc/BRIEF.md
# SPI Register-Access Peripheral with Frame CRC

This block is the serial front end of a register bank. An external controller reaches it over a four-wire SPI link in mode 0: data is sampled on the rising edge of SCLK and changed on the falling edge, most significant bit first. Every access is one fixed-length frame framed by chip-select. The frame begins with a 16-bit header. The header holds the register address, the page, a direction flag and four reserved bits. A data byte follows. When the CRC configuration input is high, an 8-bit CRC trailer comes last. The peripheral turns the frame into a single write or read on a simple register port. It checks the frame length, the reserved bits, the address and the CRC. Any failure sets a sticky error flag.

While the controller sends the header, the peripheral returns a 16-bit status word. The word carries seven status bits twice, once as they are and once inverted, with a fixed 0 and a fixed 1 as markers. The controller can use it to spot a stuck or shorted data line. In a read frame, the peripheral drives the register contents in the data slot. With CRC enabled, it then drives a CRC that covers the header it received and the data byte it sent.

All SPI pins are oversampled by the system clock through two-stage synchronizers. For that reason, each SCLK high phase and each SCLK low phase must last at least four system clock cycles.

Top module: `spi_regacc_periph`

## Requirements
- R1: The frame length is 24 SCLK rising edges when `cfg_crc_en_i` is low and 32 when it is high. The input is sampled when chip-select asserts. If chip-select deasserts after any other count, no write is made and error bit 0 (frame) is set.
- R2: The header is sent MSB first. Bits 1–8 are the address, bits 9–11 the page, bit 12 the direction (0 = write, 1 = read), and bits 13–16 are reserved. `reg_addr_o` presents {page, address}.
- R3: During bits 1–16, MISO carries: a 0, then the seven status bits S[6:0], then a 1, then ~S[6:0]. S = {err[2], err[1], err[0], stat_ext_i[3:0]}, captured when chip-select asserts.
- R4: A valid write frame causes exactly one `reg_we_o` pulse, carrying {page, address} and the data byte from bits 17–24. The pulse comes in the third clock cycle after the raw chip-select rises, counting from the first clock edge that sees it high.
- R5: A read frame drives the register data on MISO during bits 17–24, MSB first. The data is sampled from `reg_rdata_i` in the cycle after bit 16 is received, while `reg_re_o` is high.
- R6: The CRC is CRC-8: polynomial 0x07, initial value 0xFF, processed MSB first. In a write frame with CRC enabled, bits 25–32 must equal the CRC of bits 1–24. On a mismatch, no write is made and error bit 1 (CRC) is set.
- R7: In a read frame with CRC enabled, MISO carries in bits 25–32 the CRC of MOSI bits 1–16 followed by the eight read-data bits that were driven.
- R8: An access is rejected when `reg_hit_i` is low or the reserved bits are non-zero. A rejected access sets error bit 2 (address), makes no write, and a rejected read returns 0x00.
- R9: The error flags reset to 0. They stay set until `err_clr_i` is high for a cycle, and a flag set in that same cycle survives.
- R10: `spi_miso_oe_o` is low whenever the synchronized chip-select is inactive. MISO is 0 in every bit slot that R3, R5 and R7 leave undefined.
- R11: The first MISO bit is valid once chip-select has asserted. Each later bit changes only after an SCLK falling edge, so the controller can sample it on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_crc_en_i | input | 1 | Enables the CRC trailer for the next frame |
| spi_sclk_i | input | 1 | Serial clock from the controller |
| spi_cs_ni | input | 1 | Chip-select, active low |
| spi_mosi_i | input | 1 | Serial data from the controller |
| spi_miso_o | output | 1 | Serial data to the controller |
| spi_miso_oe_o | output | 1 | Output enable for MISO |
| stat_ext_i | input | 4 | External status bits placed in the status word |
| err_clr_i | input | 1 | Clears the sticky error flags |
| err_o | output | 3 | Sticky flags {address, CRC, frame} |
| reg_addr_o | output | 11 | Register address {page, address} |
| reg_we_o | output | 1 | Register write strobe |
| reg_re_o | output | 1 | Register read strobe |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data |
| reg_hit_i | input | 1 | High when `reg_addr_o` names an implemented register |

## Verification
Pin changes reach the logic two clock edges after they are driven. The output enable is therefore compared on every clock with chip-select as it stood two edges earlier. The write strobe is compared on every clock with a pulse that the bench derives three edges after chip-select rose, so a pulse one cycle early or late is caught. MISO is updated three cycles after an SCLK fall, and the bench samples it half an SCLK period later, just before the rising edge, exactly where a controller would. Flags and register contents are checked eight cycles after each frame ends, against a bench model of the register bank and its own CRC routine.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;

  localparam int ADDR_W   = 8;
  localparam int PAGE_W   = 3;
  localparam int RSVD_W   = 4;
  localparam int DATA_W   = 8;
  localparam int CRC_W    = 8;
  localparam int EXT_W    = 4;
  localparam int ERR_W    = 3;

  localparam int HDR_BITS    = ADDR_W + PAGE_W + 1 + RSVD_W;
  localparam int FRAME_SHORT = HDR_BITS + DATA_W;
  localparam int FRAME_LONG  = FRAME_SHORT + CRC_W;
  localparam int CNT_W       = $clog2(FRAME_LONG + 1);
  localparam int STAT_W      = ERR_W + EXT_W;
  localparam int REG_AW      = PAGE_W + ADDR_W;

  localparam int ERR_ADR = 2;
  localparam int ERR_CRC = 1;
  localparam int ERR_FRM = 0;

  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CRC_W-1:0] CRC_INIT = 8'hFF;

  function automatic logic [CRC_W-1:0] crc8_step(input logic [CRC_W-1:0] c, input logic b);
    logic [CRC_W-1:0] sh;
    sh = {c[CRC_W-2:0], 1'b0};
    return (c[CRC_W-1] ^ b) ? (sh ^ CRC_POLY) : sh;
  endfunction

endpackage

// File: rtl/spi_regacc_sync.sv
module spi_regacc_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/spi_regacc_crc8.sv
module spi_regacc_crc8 import spi_regacc_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [CRC_W-1:0] crc_o
);

  logic [CRC_W-1:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init_i)    crc_d = CRC_INIT;
    else if (en_i) crc_d = crc8_step(crc_q, bit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= CRC_INIT;
    else         crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/spi_regacc_txsel.sv
module spi_regacc_txsel import spi_regacc_pkg::*; (
  input  logic [CNT_W-1:0]  idx_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              rd_i,
  input  logic              crc_en_i,
  input  logic [DATA_W-1:0] rdat_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic              bit_o
);

  localparam int HW = $clog2(HDR_BITS);
  localparam int DW = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] IDX_HDR   = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] IDX_SHORT = CNT_W'(FRAME_SHORT);
  localparam logic [CNT_W-1:0] IDX_LONG  = CNT_W'(FRAME_LONG);

  logic [HDR_BITS-1:0] word;

  always_comb begin
    word  = {1'b0, stat_i, 1'b1, ~stat_i};
    bit_o = 1'b0;
    if (idx_i < IDX_HDR)
      bit_o = word[HW'(HDR_BITS-1) - idx_i[HW-1:0]];
    else if (idx_i < IDX_SHORT)
      bit_o = rd_i & rdat_i[DW'(DATA_W-1) - idx_i[DW-1:0]];
    else if (idx_i < IDX_LONG)
      bit_o = rd_i & crc_en_i & crc_i[DW'(CRC_W-1) - idx_i[DW-1:0]];
  end

endmodule

// File: rtl/spi_regacc_periph.sv
module spi_regacc_periph import spi_regacc_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_crc_en_i,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  output logic              spi_miso_o,
  output logic              spi_miso_oe_o,
  input  logic [EXT_W-1:0]  stat_ext_i,
  input  logic              err_clr_i,
  output logic [ERR_W-1:0]  err_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  input  logic              reg_hit_i
);

  localparam logic [CNT_W-1:0] CNT_MAX      = '1;
  localparam logic [CNT_W-1:0] CNT_HDR      = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR_LAST = CNT_W'(HDR_BITS - 1);
  localparam logic [CNT_W-1:0] CNT_SHORT    = CNT_W'(FRAME_SHORT);
  localparam logic [CNT_W-1:0] CNT_DAT_LAST = CNT_W'(FRAME_SHORT - 1);
  localparam logic [CNT_W-1:0] CNT_LONG     = CNT_W'(FRAME_LONG);
  localparam logic [CNT_W-1:0] CNT_CRC_LAST = CNT_W'(FRAME_LONG - 1);
  localparam logic [CNT_W-1:0] CNT_MARK     = CNT_W'(STAT_W + 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_n_s;
  spi_regacc_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) i_rst_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(1'b1), .q_o(rst_n_s)
  );

  // pin synchronizers: {sclk, cs_n, mosi}
  logic [2:0] pins_s;
  logic sclk_s, cs_n_s, mosi_s;
  spi_regacc_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_n_s),
    .d_i({spi_sclk_i, spi_cs_ni, spi_mosi_i}), .q_o(pins_s)
  );
  assign {sclk_s, cs_n_s, mosi_s} = pins_s;

  // state
  logic                sclk_q, cs_n_q;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [HDR_BITS-2:0] rx_q, rx_d;
  logic [HDR_BITS-1:0] hdr_q, hdr_d;
  logic [DATA_W-1:0]   wdat_q, wdat_d, rdat_q, rdat_d;
  logic [CRC_W-1:0]    rcrc_q, rcrc_d;
  logic                hit_q, hit_d, pend_q, pend_d, we_q, we_d;
  logic                crc_en_q, crc_en_d, miso_q, miso_d;
  logic [STAT_W-1:0]   stat_q, stat_d;
  logic [ERR_W-1:0]    err_q, err_d, err_set;

  // edge and frame events
  logic sclk_rise, sclk_fall, cs_act, cs_start, cs_end;
  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;
  assign cs_act    = ~cs_n_s;
  assign cs_start  = ~cs_n_s & cs_n_q;
  assign cs_end    = cs_n_s & ~cs_n_q;

  // header fields
  logic              hdr_rd, rsvd_ok;
  logic [PAGE_W-1:0] hdr_page;
  logic [ADDR_W-1:0] hdr_addr;
  assign hdr_addr = hdr_q[HDR_BITS-1 -: ADDR_W];
  assign hdr_page = hdr_q[RSVD_W+1 +: PAGE_W];
  assign hdr_rd   = hdr_q[RSVD_W];
  assign rsvd_ok  = (hdr_q[RSVD_W-1:0] == '0);

  // CRC engine and transmit bit selector
  logic             crc_init, crc_step, crc_bit, tx_bit;
  logic [CRC_W-1:0] crc_val;
  logic [CNT_W-1:0] frame_len;

  spi_regacc_crc8 i_crc (
    .clk_i(clk_i), .rst_ni(rst_n_s), .init_i(crc_init), .en_i(crc_step),
    .bit_i(crc_bit), .crc_o(crc_val)
  );

  spi_regacc_txsel i_txsel (
    .idx_i(cnt_q), .stat_i(stat_q), .rd_i(hdr_rd), .crc_en_i(crc_en_q),
    .rdat_i(rdat_q), .crc_i(crc_val), .bit_o(tx_bit)
  );

  assign frame_len = crc_en_q ? CNT_LONG : CNT_SHORT;

  // next state
  always_comb begin
    cnt_d    = cnt_q;
    rx_d     = rx_q;
    hdr_d    = hdr_q;
    wdat_d   = wdat_q;
    rcrc_d   = rcrc_q;
    rdat_d   = rdat_q;
    hit_d    = hit_q;
    crc_en_d = crc_en_q;
    stat_d   = stat_q;
    miso_d   = miso_q;
    pend_d   = 1'b0;
    we_d     = 1'b0;
    err_set  = '0;
    crc_init = 1'b0;
    crc_step = 1'b0;
    crc_bit  = mosi_s;

    if (cs_start) begin
      cnt_d    = '0;
      crc_init = 1'b1;
      crc_en_d = cfg_crc_en_i;
      stat_d   = {err_q, stat_ext_i};
      miso_d   = 1'b0;
    end else if (cs_act) begin
      if (sclk_rise) begin
        rx_d = {rx_q[HDR_BITS-3:0], mosi_s};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_W'(1);
        if (cnt_q < CNT_SHORT) begin
          crc_step = 1'b1;
          if (cnt_q >= CNT_HDR && hdr_rd) crc_bit = miso_q;
        end
        if (cnt_q == CNT_HDR_LAST) begin
          hdr_d  = {rx_q, mosi_s};
          pend_d = 1'b1;
        end
        if (cnt_q == CNT_DAT_LAST) wdat_d = {rx_q[DATA_W-2:0], mosi_s};
        if (cnt_q == CNT_CRC_LAST) rcrc_d = {rx_q[CRC_W-2:0], mosi_s};
      end
      if (sclk_fall) miso_d = tx_bit;
    end

    if (pend_q) begin
      hit_d  = reg_hit_i;
      rdat_d = (hdr_rd && reg_hit_i && rsvd_ok) ? reg_rdata_i : '0;
    end

    if (cs_end) begin
      if (cnt_q != frame_len)                      err_set[ERR_FRM] = 1'b1;
      else if (!rsvd_ok || !hit_q)                 err_set[ERR_ADR] = 1'b1;
      else if (!hdr_rd && crc_en_q && rcrc_q != crc_val) err_set[ERR_CRC] = 1'b1;
      else if (!hdr_rd)                            we_d = 1'b1;
    end

    err_d = (err_clr_i ? '0 : err_q) | err_set;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_n_s) begin
    if (!rst_n_s) begin
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      cnt_q    <= '0;
      rx_q     <= '0;
      hdr_q    <= '0;
      wdat_q   <= '0;
      rcrc_q   <= '0;
      rdat_q   <= '0;
      hit_q    <= 1'b0;
      pend_q   <= 1'b0;
      we_q     <= 1'b0;
      crc_en_q <= 1'b0;
      stat_q   <= '0;
      miso_q   <= 1'b0;
      err_q    <= '0;
    end else begin
      sclk_q   <= sclk_s;
      cs_n_q   <= cs_n_s;
      cnt_q    <= cnt_d;
      rx_q     <= rx_d;
      hdr_q    <= hdr_d;
      wdat_q   <= wdat_d;
      rcrc_q   <= rcrc_d;
      rdat_q   <= rdat_d;
      hit_q    <= hit_d;
      pend_q   <= pend_d;
      we_q     <= we_d;
      crc_en_q <= crc_en_d;
      stat_q   <= stat_d;
      miso_q   <= miso_d;
      err_q    <= err_d;
    end
  end

  // outputs
  assign spi_miso_o    = miso_q;
  assign spi_miso_oe_o = cs_act;
  assign err_o         = err_q;
  assign reg_addr_o    = {hdr_page, hdr_addr};
  assign reg_wdata_o   = wdat_q;
  assign reg_we_o      = we_q;
  assign reg_re_o      = pend_q & hdr_rd;

  // checks beside the logic they guard
  assert_we_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    reg_we_o |-> cs_n_s);

  assert_first_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    cs_start |=> !spi_miso_o);

  assert_marker_one_R3: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cs_act && !cs_start && sclk_fall && cnt_q == CNT_MARK) |=> spi_miso_o);

  assert_crc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (cs_act && !cs_start && cnt_q >= CNT_SHORT) |=> $stable(crc_val));

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !err_clr_i |=> ((err_q & $past(err_q)) == $past(err_q)));

  assert_clean_commit_R6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (reg_we_o && !$past(err_clr_i)) |-> (err_q == $past(err_q)));

endmodule

// File: tb/test_spi_regacc_periph.sv
module test_spi_regacc_periph;

  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        crc_on = 1'b0;
  logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic        miso, miso_oe;
  logic [3:0]  ext = 4'b1010;
  logic        err_clr = 1'b0;
  logic [2:0]  err;
  logic [10:0] reg_addr;
  logic        reg_we, reg_re, reg_hit;
  logic [7:0]  reg_wdata, reg_rdata;

  spi_regacc_periph i_spi_regacc_periph (
    .clk_i(clk), .rst_ni(rst_n), .cfg_crc_en_i(crc_on),
    .spi_sclk_i(sclk), .spi_cs_ni(cs_n), .spi_mosi_i(mosi),
    .spi_miso_o(miso), .spi_miso_oe_o(miso_oe),
    .stat_ext_i(ext), .err_clr_i(err_clr), .err_o(err),
    .reg_addr_o(reg_addr), .reg_we_o(reg_we), .reg_re_o(reg_re),
    .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata), .reg_hit_i(reg_hit)
  );

  // register bank behind the port: page 0, addresses 0x00..0x0F
  logic [7:0] rf [16];
  logic [7:0] exp_mem [16];
  assign reg_hit   = (reg_addr[10:8] == 3'd0) && (reg_addr[7:4] == 4'd0);
  assign reg_rdata = rf[reg_addr[3:0]];
  always @(posedge clk) if (reg_we && reg_hit) rf[reg_addr[3:0]] <= reg_wdata;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [2:0]  exp_err = 3'b000;
  bit          exp_commit = 1'b0;
  logic [10:0] exp_waddr = '0;
  logic [7:0]  exp_wdata = '0;
  int          we_seen = 0;
  bit          mon_en = 1'b0;

  // chip-select history, one entry per clock edge
  logic h1 = 1'b1, h2 = 1'b1, h3 = 1'b1, h4 = 1'b1;
  always @(posedge clk) begin
    h1 <= cs_n; h2 <= h1; h3 <= h2; h4 <= h3;
  end

  // per-clock comparison against the model
  always @(negedge clk) if (mon_en) begin
    chk(miso_oe == !h2, "R10", "miso_oe", miso_oe, !h2);
    chk(reg_we == (h3 && !h4 && exp_commit), "R4", "reg_we timing",
        reg_we, (h3 && !h4 && exp_commit));
    if (reg_we) begin
      we_seen++;
      chk(reg_addr == exp_waddr, "R2", "write address", reg_addr, exp_waddr);
      chk(reg_wdata == exp_wdata, "R4", "write data", reg_wdata, exp_wdata);
    end
  end

  function automatic logic [7:0] crc_ref(input logic [23:0] bits);
    logic [7:0] c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      logic fb = c[7] ^ bits[i];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic frame(input logic [7:0] a, input logic [2:0] pg, input bit rd,
                       input logic [3:0] rs, input logic [7:0] wd, input int nbits,
                       input bit bad_crc, input string req);
    logic [15:0] hdr;
    logic [7:0]  rexp, tcrc;
    logic [6:0]  st;
    logic [39:0] mo, ex, got, mask;
    bit          hit, complete, commit;
    logic [2:0]  nerr;
    int          len;
    hdr  = {a, pg, rd, rs};
    hit  = (pg == 3'd0) && (a < 8'd16);
    len  = crc_on ? 32 : 24;
    rexp = (rd && hit && rs == 4'd0) ? exp_mem[a[3:0]] : 8'h00;
    tcrc = crc_on ? (crc_ref({hdr, wd}) ^ {7'b0, bad_crc}) : 8'h00;
    mo   = {hdr, rd ? 8'h00 : wd, tcrc, 8'h00};
    st   = {exp_err, ext};
    ex   = {1'b0, st, 1'b1, ~st, rd ? rexp : 8'h00,
            (rd && crc_on) ? crc_ref({hdr, rexp}) : 8'h00, 8'h00};
    complete = (nbits == len);
    commit = 1'b0;
    nerr = 3'b000;
    if (!complete)                      nerr[0] = 1'b1;
    else if (rs != 4'd0 || !hit)        nerr[2] = 1'b1;
    else if (!rd && crc_on && bad_crc)  nerr[1] = 1'b1;
    else if (!rd)                       commit = 1'b1;
    exp_commit = commit;
    exp_waddr  = {pg, a};
    exp_wdata  = wd;
    we_seen    = 0;
    got = '0;

    @(negedge clk);
    cs_n = 1'b0;
    for (int i = 0; i < nbits; i++) begin
      mosi = mo[39-i];
      repeat (HALF) @(negedge clk);
      got[39-i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    mosi = 1'b0;
    repeat (8) @(negedge clk);

    mask = ~(40'hFF_FFFF_FFFF >> nbits);
    chk((got & mask) == (ex & mask), {req, " R3 R11"}, "miso stream", got & mask, ex & mask);
    exp_err = exp_err | nerr;
    if (commit) exp_mem[a[3:0]] = wd;
    chk(we_seen == int'(commit), req, "write count", we_seen, commit);
    chk(err == exp_err, req, "error flags", err, exp_err);
    exp_commit = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    exp_err = 3'b000;
    repeat (2) @(negedge clk);
    chk(err == 3'b000, "R9", "flags after clear", err, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      rf[i] = 8'h40 + 8'(i);
      exp_mem[i] = 8'h40 + 8'(i);
    end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mon_en = 1'b1;
    chk(err == 3'b000, "R9", "reset flags", err, 0);
    chk(miso_oe == 1'b0, "R10", "reset oe", miso_oe, 0);
    chk(reg_we == 1'b0, "R4", "reset we", reg_we, 0);

    // plain write and read back, CRC off
    frame(8'h03, 3'd0, 1'b0, 4'h0, 8'hA5, 24, 1'b0, "R2 R4 R10");
    frame(8'h03, 3'd0, 1'b1, 4'h0, 8'h00, 24, 1'b0, "R5");
    ext = 4'b0101;
    frame(8'h0F, 3'd0, 1'b0, 4'h0, 8'h3C, 24, 1'b0, "R4");
    frame(8'h0F, 3'd0, 1'b1, 4'h0, 8'h00, 24, 1'b0, "R5");

    // unimplemented addresses
    frame(8'h00, 3'd1, 1'b0, 4'h0, 8'h77, 24, 1'b0, "R8");
    frame(8'h00, 3'd0, 1'b1, 4'h0, 8'h00, 24, 1'b0, "R8");
    frame(8'h40, 3'd0, 1'b1, 4'h0, 8'h00, 24, 1'b0, "R8");
    clear_flags();

    // reserved bits set
    frame(8'h02, 3'd0, 1'b0, 4'h4, 8'h55, 24, 1'b0, "R8");
    frame(8'h02, 3'd0, 1'b1, 4'h0, 8'h00, 24, 1'b0, "R8");
    clear_flags();

    // wrong lengths
    frame(8'h04, 3'd0, 1'b0, 4'h0, 8'h11, 20, 1'b0, "R1");
    frame(8'h04, 3'd0, 1'b0, 4'h0, 8'h22, 25, 1'b0, "R1");
    frame(8'h04, 3'd0, 1'b1, 4'h0, 8'h00, 24, 1'b0, "R1");
    clear_flags();

    // CRC enabled
    crc_on = 1'b1;
    ext = 4'b1100;
    frame(8'h05, 3'd0, 1'b0, 4'h0, 8'hC3, 32, 1'b0, "R6");
    frame(8'h05, 3'd0, 1'b1, 4'h0, 8'h00, 32, 1'b0, "R7");
    frame(8'h06, 3'd0, 1'b0, 4'h0, 8'h99, 32, 1'b1, "R6");
    frame(8'h06, 3'd0, 1'b1, 4'h0, 8'h00, 32, 1'b0, "R6 R7");
    frame(8'h07, 3'd0, 1'b0, 4'h0, 8'h12, 24, 1'b0, "R1");
    clear_flags();
    frame(8'h07, 3'd0, 1'b1, 4'h0, 8'h00, 32, 1'b0, "R1 R7");
    frame(8'h41, 3'd0, 1'b1, 4'h0, 8'h00, 32, 1'b0, "R8 R7");

    mon_en = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule